// File: doc/BRIEF.md
# Serial DAC Command Sender

This block sits on the host side of a four-channel, 8-bit serial digital-to-analog converter. A client hands it one command at a time through a valid/ready handshake. The command carries a channel index, a power-down bit, a speed-select bit, an 8-bit output code and a deferred-update flag. The block packs these fields into a 16-bit word and shifts it out over a chip-select, frame-sync, serial-clock and data interface. Every edge of that interface is spaced in whole half-periods of the serial clock, and each half-period is a fixed number of system clocks.

A separate load output controls when the converter copies new codes into its outputs. While the last accepted command asked for a deferred update, the load line is held high, so any number of channels can be written without their outputs moving. A one-cycle commit request then drives the load line low for a configurable number of system cycles, and all pending channels update together. If a frame is in flight when the commit arrives, the strobe waits until that frame has fully finished.

The half-period divider is a parameter. At elaboration it is checked against the system clock period, so that no serial-clock phase can be shorter than 25 ns.

Top module: `dac_cmd_sender`

## Requirements
- R1: Each frame carries 16 bits, most significant first. Bits 15:14 hold the channel index, bit 13 the power-down bit, bit 12 the speed bit, bits 11:4 the code, and bits 3:0 are zero.
- R2: The serial clock rests high whenever chip select is high. The data line changes during a frame only on a rising serial-clock edge, so that it is stable across every falling edge, where the receiver samples it.
- R3: Chip select falls in the cycle after a command is accepted. Frame sync falls exactly one half-period (HALF_DIV system cycles) later, and the first falling serial-clock edge follows one further half-period after that.
- R4: Every high and every low phase of the serial clock lasts HALF_DIV system cycles. Elaboration fails if HALF_DIV times the system clock period is below 25 ns.
- R5: Exactly 16 falling serial-clock edges occur while frame sync is low. Frame sync rises together with the rising edge one half-period after the 16th fall. Chip select rises one half-period after that, with the serial clock high.
- R6: Ready is low from the acceptance edge until 35 half-periods later. Frame sync stays high for at least three half-periods between frames.
- R7: After reset, chip select, frame sync and serial clock are high, data is 0, the load output is low and ready is high.
- R8: Accepting a command with the deferred flag set drives the load output high from the acceptance cycle. Accepting a command without the flag drives it low from its acceptance cycle.
- R9: A commit request that is seen while no frame is active drives the load output low for LOAD_PULSE cycles, starting in the next cycle, and ready stays low until the pulse ends. A commit seen during a frame, or at that frame's own acceptance edge, starts its pulse one cycle after the frame returns to idle.
- R10: The load output never changes while chip select stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block can take a command this cycle |
| cmd_chan | input | ADDR_W | Channel index |
| cmd_pwr | input | 1 | Power-down bit of the command |
| cmd_spd | input | 1 | Speed-select bit of the command |
| cmd_code | input | CODE_W | Output code |
| cmd_defer | input | 1 | Hold the load output high after this command |
| commit_req | input | 1 | Request a simultaneous-update strobe |
| dac_cs_n | output | 1 | Chip select, active low |
| dac_fs | output | 1 | Frame sync, low during the shifted bits |
| dac_sclk | output | 1 | Serial clock, idles high |
| dac_din | output | 1 | Serial data |
| dac_load_n | output | 1 | Load strobe, low lets outputs update |

## Verification
A command acceptance and a commit request can land on the same clock edge. That edge both starts a frame and arms a strobe that must not fire until the frame has ended. The bench provokes this by raising cmd_valid and commit_req together while ready is high. It then judges the outcome from the ports: the load output must stay constant for the whole time chip select is low, and it must fall exactly 35 half-periods plus one cycle after acceptance. It must stay low for LOAD_PULSE cycles, and ready must return only when the strobe ends. A plain idle commit and a full sweep of channels, control bits and codes are judged against arithmetic edge times computed from the acceptance cycle.

// File: rtl/dcs_pkg.sv
package dcs_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CSSET,
      ST_FSSET,
      ST_LOW,
      ST_HIGH,
      ST_TAIL,
      ST_GAP
   } dcs_state_e;

   typedef struct packed {
      logic cs_n;
      logic fs;
      logic sclk;
   } dcs_pins_t;

   // Pin levels held for the whole of each half-period state.
   function automatic dcs_pins_t pins_of(dcs_state_e s);
      dcs_pins_t p;
      case (s)
         ST_CSSET: p = '{cs_n: 1'b0, fs: 1'b1, sclk: 1'b1};
         ST_FSSET: p = '{cs_n: 1'b0, fs: 1'b0, sclk: 1'b1};
         ST_LOW:   p = '{cs_n: 1'b0, fs: 1'b0, sclk: 1'b0};
         ST_HIGH:  p = '{cs_n: 1'b0, fs: 1'b0, sclk: 1'b1};
         ST_TAIL:  p = '{cs_n: 1'b0, fs: 1'b1, sclk: 1'b1};
         default:  p = '{cs_n: 1'b1, fs: 1'b1, sclk: 1'b1};
      endcase
      return p;
   endfunction

endpackage

// File: rtl/dcs_half_tick.sv
module dcs_half_tick #(
   parameter int HALF_DIV = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
   localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

   logic [CW-1:0] cnt_q;

   assign tick = run && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (!run)    cnt_q <= '0;
      else if (tick)    cnt_q <= '0;
      else              cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/dcs_framer.sv
module dcs_framer
   import dcs_pkg::*;
#(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [WORD_W-1:0] word,
   input  logic              tick,
   output logic              idle,
   output logic              cs_n,
   output logic              fs,
   output logic              sclk,
   output logic              din
);
   localparam int BW = $clog2(WORD_W);
   localparam logic [BW-1:0] LAST_BIT = BW'(WORD_W - 1);

   dcs_state_e        state_q, state_d;
   logic [WORD_W-1:0] sr_q;
   logic [BW-1:0]     bit_q;
   dcs_pins_t         pins_q;
   logic              last;

   assign last = (bit_q == LAST_BIT);
   assign idle = (state_q == ST_IDLE);

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_IDLE:  if (start) state_d = ST_CSSET;
         ST_CSSET: if (tick)  state_d = ST_FSSET;
         ST_FSSET: if (tick)  state_d = ST_LOW;
         ST_LOW:   if (tick)  state_d = last ? ST_TAIL : ST_HIGH;
         ST_HIGH:  if (tick)  state_d = ST_LOW;
         ST_TAIL:  if (tick)  state_d = ST_GAP;
         ST_GAP:   if (tick)  state_d = ST_IDLE;
         default:             state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         sr_q    <= '0;
         bit_q   <= '0;
         pins_q  <= '{cs_n: 1'b1, fs: 1'b1, sclk: 1'b1};
      end else begin
         state_q <= state_d;
         pins_q  <= pins_of(state_d);
         if (state_q == ST_IDLE && start) begin
            sr_q  <= word;
            bit_q <= '0;
         end else if (state_q == ST_LOW && tick && !last) begin
            sr_q  <= {sr_q[WORD_W-2:0], 1'b0};
            bit_q <= bit_q + 1'b1;
         end else if (state_q == ST_TAIL && tick) begin
            sr_q  <= '0;
         end
      end
   end

   assign cs_n = pins_q.cs_n;
   assign fs   = pins_q.fs;
   assign sclk = pins_q.sclk;
   assign din  = sr_q[WORD_W-1];
endmodule

// File: rtl/dcs_load_ctrl.sv
module dcs_load_ctrl #(
   parameter int LOAD_PULSE = 4,
   parameter bit LOAD_EN    = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic accept,
   input  logic defer,
   input  logic commit_req,
   input  logic frame_idle,
   output logic load_n,
   output logic busy
);
   localparam int PW = (LOAD_PULSE > 1) ? $clog2(LOAD_PULSE) : 1;

   generate
      if (LOAD_EN) begin : g_strobe
         logic          hold_q, pend_q, puls_q;
         logic [PW-1:0] pcnt_q;
         logic          fire;

         assign fire = pend_q && frame_idle && !puls_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               hold_q <= 1'b0;
               pend_q <= 1'b0;
               puls_q <= 1'b0;
               pcnt_q <= '0;
            end else begin
               if (accept) hold_q <= defer;
               if (commit_req) pend_q <= 1'b1;
               else if (fire)  pend_q <= 1'b0;
               if (fire) begin
                  puls_q <= 1'b1;
                  pcnt_q <= PW'(LOAD_PULSE - 1);
               end else if (puls_q) begin
                  if (pcnt_q == '0) puls_q <= 1'b0;
                  else              pcnt_q <= pcnt_q - 1'b1;
               end
            end
         end

         assign load_n = hold_q && !puls_q;
         assign busy   = pend_q || puls_q;
      end else begin : g_tied
         assign load_n = 1'b0;
         assign busy   = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/dac_cmd_sender.sv
module dac_cmd_sender #(
   parameter int SYS_PERIOD_PS = 10000,
   parameter int HALF_DIV      = 3,
   parameter int LOAD_PULSE    = 4,
   parameter bit LOAD_EN       = 1'b1,
   parameter int ADDR_W        = 2,
   parameter int CODE_W        = 8,
   parameter int PAD_W         = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic [ADDR_W-1:0] cmd_chan,
   input  logic              cmd_pwr,
   input  logic              cmd_spd,
   input  logic [CODE_W-1:0] cmd_code,
   input  logic              cmd_defer,
   input  logic              commit_req,
   output logic              dac_cs_n,
   output logic              dac_fs,
   output logic              dac_sclk,
   output logic              dac_din,
   output logic              dac_load_n
);
   localparam int WORD_W       = ADDR_W + 2 + CODE_W + PAD_W;
   localparam int MIN_PHASE_PS = 25000;

   generate
      if (HALF_DIV < 1) begin : g_bad_div
         $error("HALF_DIV must be at least 1");
      end
      if (HALF_DIV * SYS_PERIOD_PS < MIN_PHASE_PS) begin : g_bad_phase
         $error("serial clock phase shorter than 25 ns");
      end
      if (LOAD_PULSE < 1) begin : g_bad_pulse
         $error("LOAD_PULSE must be at least 1");
      end
   endgenerate

   logic              tick, idle, accept, load_busy;
   logic [WORD_W-1:0] word;

   assign cmd_ready = idle && !load_busy;
   assign accept    = cmd_valid && cmd_ready;
   assign word      = {cmd_chan, cmd_pwr, cmd_spd, cmd_code, {PAD_W{1'b0}}};

   dcs_half_tick #(.HALF_DIV(HALF_DIV)) u_tick (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (!idle),
      .tick (tick)
   );

   dcs_framer #(.WORD_W(WORD_W)) u_frm (
      .clk  (clk),
      .rst_n(rst_n),
      .start(accept),
      .word (word),
      .tick (tick),
      .idle (idle),
      .cs_n (dac_cs_n),
      .fs   (dac_fs),
      .sclk (dac_sclk),
      .din  (dac_din)
   );

   dcs_load_ctrl #(.LOAD_PULSE(LOAD_PULSE), .LOAD_EN(LOAD_EN)) u_ld (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept),
      .defer     (cmd_defer),
      .commit_req(commit_req),
      .frame_idle(idle),
      .load_n    (dac_load_n),
      .busy      (load_busy)
   );
endmodule

// File: rtl/dcs_checker.sv
module dcs_checker #(
   parameter int HALF_DIV = 3
) (
   input logic clk,
   input logic rst_n,
   input logic cs_n,
   input logic fs,
   input logic sclk,
   input logic din,
   input logic cmd_ready,
   input logic load_n
);
   logic        sclk_q;
   logic [15:0] run_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q  <= 1'b1;
         run_len <= '1;
      end else begin
         sclk_q <= sclk;
         if (sclk != sclk_q)      run_len <= 16'd1;
         else if (run_len != '1)  run_len <= run_len + 1'b1;
      end
   end

   // R3: chip select already low before frame sync falls
   a_r3_cs_before_fs: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(fs) |-> (!cs_n && $past(!cs_n)));

   // R3: frame sync low before any falling serial clock
   a_r3_fs_before_sclk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sclk) |-> (!fs && $past(!fs)));

   // R2: data moves inside a frame only with a rising serial clock
   a_r2_din_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && $past(!cs_n) && !$stable(din)) |-> $rose(sclk));

   // R2: serial clock rests high outside a frame
   a_r2_sclk_idle: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> sclk);

   // R4: each serial clock phase lasts at least HALF_DIV cycles
   a_r4_phase_width: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk != sclk_q) |-> (run_len >= 16'(HALF_DIV)));

   // R5: chip select released only with clock and frame sync high
   a_r5_cs_release: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n) |-> (fs && sclk && $past(sclk)));

   // R5: frame sync low only inside chip select
   a_r5_fs_inside_cs: assert property (@(posedge clk) disable iff (!rst_n)
      !fs |-> !cs_n);

   // R6: no new command while a frame is on the wire
   a_r6_ready_busy: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_n |-> !cmd_ready);

   // R10: load output steady during a frame
   a_r10_load_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && $past(!cs_n)) |-> $stable(load_n));
endmodule

bind dac_cmd_sender dcs_checker #(.HALF_DIV(HALF_DIV)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cs_n     (dac_cs_n),
   .fs       (dac_fs),
   .sclk     (dac_sclk),
   .din      (dac_din),
   .cmd_ready(cmd_ready),
   .load_n   (dac_load_n)
);

// File: tb/sim_dac_cmd_sender.sv
module sim_dac_cmd_sender;
   localparam int CLK_PERIOD = 10;
   localparam int H          = 3;
   localparam int LP         = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_valid = 1'b0;
   logic       cmd_ready;
   logic [1:0] cmd_chan = '0;
   logic       cmd_pwr = 1'b0, cmd_spd = 1'b0, cmd_defer = 1'b0;
   logic [7:0] cmd_code = '0;
   logic       commit_req = 1'b0;
   logic       cs_n, fs, sclk, din, load_n;

   always #(CLK_PERIOD/2) clk = ~clk;

   dac_cmd_sender #(.SYS_PERIOD_PS(10000), .HALF_DIV(H), .LOAD_PULSE(LP)) u0 (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_chan(cmd_chan), .cmd_pwr(cmd_pwr), .cmd_spd(cmd_spd),
      .cmd_code(cmd_code), .cmd_defer(cmd_defer), .commit_req(commit_req),
      .dac_cs_n(cs_n), .dac_fs(fs), .dac_sclk(sclk), .dac_din(din),
      .dac_load_n(load_n)
   );

   int checks = 0, fails = 0, cyc = 0;
   bit done = 0;

   always @(posedge clk) cyc <= cyc + 1;

   // receiver-side monitor, sampled on the falling system clock
   int t_csfall, t_fsfall, t_first, t_fsrise, t_csrise, t_rdy, t_ldfall, t_ldrise;
   int t_sck = 0, nbits = 0, phase_bad = 0, din_bad = 0, ld_bad = 0;
   logic [15:0] rx = '0;
   logic p_cs = 1, p_fs = 1, p_sclk = 1, p_din = 0, p_ld = 0, p_rdy = 1;

   always @(negedge clk) if (rst_n) begin
      if (p_cs && !cs_n) begin t_csfall = cyc; nbits = 0; rx = '0; end
      if (!cs_n && p_fs && !fs) t_fsfall = cyc;
      if (!cs_n && !fs && p_sclk && !sclk) begin
         if (nbits == 0) t_first = cyc;
         rx = {rx[14:0], din};
         nbits++;
      end
      if (sclk != p_sclk) begin
         if (cyc - t_sck < H) phase_bad++;
         t_sck = cyc;
      end
      if (!cs_n && !p_cs && din != p_din && !(sclk && !p_sclk)) din_bad++;
      if (!p_fs && fs) t_fsrise = cyc;
      if (!p_cs && cs_n) t_csrise = cyc;
      if (p_ld && !load_n) t_ldfall = cyc;
      if (!p_ld && load_n) t_ldrise = cyc;
      if (!cs_n && !p_cs && load_n != p_ld) ld_bad++;
      if (!p_rdy && cmd_ready) t_rdy = cyc;
      p_cs = cs_n; p_fs = fs; p_sclk = sclk; p_din = din; p_ld = load_n; p_rdy = cmd_ready;
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // send one command; optional commit on the same acceptance edge
   task automatic send(input int ch, input bit pw, input bit sp, input int code,
                       input bit dfr, input bit cmt, output int acc);
      @(negedge clk);
      while (!cmd_ready) @(negedge clk);
      cmd_chan = 2'(ch); cmd_pwr = pw; cmd_spd = sp; cmd_code = 8'(code);
      cmd_defer = dfr; cmd_valid = 1'b1; commit_req = cmt;
      @(negedge clk);
      acc = cyc;
      cmd_valid = 1'b0; commit_req = 1'b0;
      while (!cmd_ready) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic frame_checks(input int ch, input bit pw, input bit sp, input int code,
                               input int a, input int rdy_exp);
      logic [15:0] exp_w;
      exp_w = {2'(ch), pw, sp, 8'(code), 4'b0000};
      chk(rx == exp_w, "R1 frame word", int'(rx), int'(exp_w));
      chk(nbits == 16, "R5 falling edges per frame", nbits, 16);
      chk(t_csfall == a, "R3 cs fall cycle", t_csfall, a);
      chk(t_fsfall == a + H, "R3 fs fall cycle", t_fsfall, a + H);
      chk(t_first == a + 2*H, "R3 first sclk fall", t_first, a + 2*H);
      chk(t_fsrise == a + 33*H, "R5 fs rise cycle", t_fsrise, a + 33*H);
      chk(t_csrise == a + 34*H, "R5 cs rise cycle", t_csrise, a + 34*H);
      chk(t_rdy == rdy_exp, "R6 ready return", t_rdy, rdy_exp);
      chk(phase_bad == 0, "R4 sclk phase width", phase_bad, 0);
      chk(din_bad == 0, "R2 data changes on rising edge", din_bad, 0);
      chk(ld_bad == 0, "R10 load steady in frame", ld_bad, 0);
   endtask

   initial begin
      int a, c;
      int codes[4] = '{8'h00, 8'hFF, 8'hA5, 8'h5A};
      repeat (3) @(negedge clk);
      // R7 reset state
      chk(cs_n == 1 && fs == 1 && sclk == 1, "R7 reset pins", {cs_n, fs, sclk}, 7);
      chk(din == 0 && load_n == 0, "R7 reset data/load", {din, load_n}, 0);
      chk(cmd_ready == 1, "R7 reset ready", cmd_ready, 1);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // sweep of channel, control bits and codes, immediate update
      for (int ch = 0; ch < 4; ch++)
         for (int pw = 0; pw < 2; pw++)
            for (int sp = 0; sp < 2; sp++)
               for (int k = 0; k < 4; k++) begin
                  send(ch, pw[0], sp[0], codes[k], 1'b0, 1'b0, a);
                  frame_checks(ch, pw[0], sp[0], codes[k], a, a + 35*H);
                  chk(load_n == 0, "R8 immediate keeps load low", load_n, 0);
               end

      // R8 deferred batch holds load high
      send(0, 1'b0, 1'b1, 8'h12, 1'b1, 1'b0, a);
      frame_checks(0, 1'b0, 1'b1, 8'h12, a, a + 35*H);
      chk(t_ldrise == a, "R8 load rises at deferred accept", t_ldrise, a);
      send(1, 1'b0, 1'b0, 8'h34, 1'b1, 1'b0, a);
      frame_checks(1, 1'b0, 1'b0, 8'h34, a, a + 35*H);
      chk(load_n == 1, "R8 load held across batch", load_n, 1);

      // R9 commit while idle
      @(negedge clk);
      commit_req = 1'b1;
      @(negedge clk);
      c = cyc;
      commit_req = 1'b0;
      chk(cmd_ready == 0, "R9 ready low on commit", cmd_ready, 0);
      while (!cmd_ready) @(negedge clk);
      @(negedge clk);
      chk(t_ldfall == c + 1, "R9 idle pulse start", t_ldfall, c + 1);
      chk(t_ldrise == c + LP + 1, "R9 idle pulse end", t_ldrise, c + LP + 1);
      chk(t_rdy == c + LP + 1, "R9 ready after pulse", t_rdy, c + LP + 1);

      // R9 commit on the same edge as a deferred command
      send(2, 1'b1, 1'b0, 8'h77, 1'b1, 1'b1, a);
      frame_checks(2, 1'b1, 1'b0, 8'h77, a, a + 35*H + LP + 1);
      chk(t_ldfall == a + 35*H + 1, "R9 pulse waits for frame", t_ldfall, a + 35*H + 1);
      chk(t_ldrise == a + 35*H + LP + 1, "R9 pulse width after frame", t_ldrise, a + 35*H + LP + 1);
      chk(load_n == 1, "R8 hold restored after pulse", load_n, 1);

      // R8 immediate command clears the hold at its acceptance
      send(3, 1'b0, 1'b1, 8'hC3, 1'b0, 1'b0, a);
      frame_checks(3, 1'b0, 1'b1, 8'hC3, a, a + 35*H);
      chk(t_ldfall == a, "R8 load falls at immediate accept", t_ldfall, a);
      chk(load_n == 0, "R8 load low after immediate", load_n, 0);

      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule